// File: doc/BRIEF.md
# Sensorless Spindle Startup Commutation Sequencer

This block brings a sensorless three-phase spindle motor from standstill into self-timed rotation. When the enable requests drive, it starts an open-loop synchronous phase. It steps through a six-step source/sink pattern, and each step lasts a number of startup-oscillator ticks that grows with the step count. Once enough back-EMF zero-crossing pulses have been seen, it hands commutation over to those crossings. After that point, every crossing advances the pattern by one step. If crossings stop arriving for a programmable number of system clocks, the motor is taken as stopped and synchronous startup begins again from the first step.

A three-level enable (2-bit code) selects drive, all-off or brake. Brake pulls all three phases to sink. An over-temperature flag or a loss of power forces every phase off. A restart-inhibit input decides whether the motor may start again after a power loss without a fresh enable cycle. Analog drivers and current shaping lie outside the block.

State machine: states OFF, BRAKE, SYNC (open-loop startup) and RUN (back-EMF timed). The transitions are:
- any state to OFF on over-temperature, power loss, enable open, or an inhibited restart;
- any state to BRAKE on enable brake;
- OFF or BRAKE to SYNC on enable drive;
- SYNC to RUN on lock;
- RUN to SYNC on stop timeout.

Top module: `spin_start_seq`

## Requirements
- R1: In SYNC the step lengths, counted in osc_tick pulses, are 4 for each of the first five steps, then 6, 8, 10, 12 and 14, then 16 for every later step. The schedule restarts each time SYNC is entered.
- R2: In SYNC and RUN, step index s (0..5, wrapping) drives exactly one phase to source (code 01), one phase to sink (code 10) and one phase off (code 00). The source/sink pairs in step order are U/V, U/W, V/W, V/U, W/U, W/V. Entering SYNC selects step 0.
- R3: In SYNC, the ZC_LOCK-th zc_pulse (default 2) moves the block to RUN without a step change. In RUN, each zc_pulse advances the step by one. osc_tick has no effect in RUN, and zc_pulse has no effect in OFF.
- R4: In RUN, if STOP_TO consecutive clocks pass without a zc_pulse after the last one, the block re-enters SYNC at step 0 on the STOP_TO-th clock.
- R5: spn_en codes: 2'b10 is drive, 2'b01 is brake, 2'b00 is open, and 2'b11 is also treated as open. Drive leads from OFF or BRAKE to SYNC one clock later. Open leads to OFF one clock later.
- R6: In BRAKE all three phases are sink (10), for as long as brake is held.
- R7: While ovt is high or pwr_ok is low, the block is in OFF with all phases off from the next clock on. When the fault clears with drive still requested, SYNC restarts at step 0.
- R8: If pwr_ok falls in SYNC or RUN while restart_inh is high, the block stays in OFF after power returns until spn_en leaves drive. With restart_inh low, startup resumes as soon as power returns.
- R9: mode reports OFF=00, BRAKE=01, SYNC=10, RUN=11. In OFF all phases are 00.
- R10: After reset, mode is OFF and all phases are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-clock pulse per startup-oscillator period |
| zc_pulse | input | 1 | One-clock pulse per back-EMF zero crossing |
| spn_en | input | 2 | Spindle enable: 10 drive, 01 brake, 00/11 open |
| ovt | input | 1 | Over-temperature flag, high active |
| pwr_ok | input | 1 | Supply good, high active |
| restart_inh | input | 1 | Inhibit automatic restart after power loss |
| ph_u | output | 2 | Phase U code: 00 off, 01 source, 10 sink |
| ph_v | output | 2 | Phase V code |
| ph_w | output | 2 | Phase W code |
| mode | output | 2 | Mode code: 00 off, 01 brake, 10 sync, 11 run |

## Verification
The assertions cover the invariants that hold on every clock:
- one source and one sink in every commutating state;
- all-sink in brake and all-off in OFF;
- faults forcing OFF one clock later;
- the tick and stop counters staying inside their bounds;
- the inhibit latch keeping the machine out of SYNC and RUN.

Only the bench scenarios can show the exact step-length schedule under random tick spacing and the lock after the second crossing. The same applies to the exact clock on which a stop restarts startup, and to restart with and without inhibit after a power loss.

// File: rtl/sss_pkg.sv
package sss_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_BRAKE = 2'b01,
        MODE_SYNC  = 2'b10,
        MODE_RUN   = 2'b11
    } mode_e;

    localparam logic [1:0] PH_OFF  = 2'b00;
    localparam logic [1:0] PH_SRC  = 2'b01;
    localparam logic [1:0] PH_SINK = 2'b10;

    localparam logic [1:0] EN_OPEN  = 2'b00;
    localparam logic [1:0] EN_BRAKE = 2'b01;
    localparam logic [1:0] EN_DRIVE = 2'b10;
endpackage

// File: rtl/sss_step_timer.sv
module sss_step_timer #(
    parameter int unsigned FIRST_LEN = 4,
    parameter int unsigned FIRST_CNT = 5,
    parameter int unsigned GROW      = 2,
    parameter int unsigned FINAL_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic step_done
);
    localparam int unsigned CW = $clog2(FINAL_LEN + 1);

    logic [CW-1:0] tcnt;
    logic [7:0]    kcnt;
    logic [CW-1:0] len;
    int unsigned   grown;

    // Step length from the number of steps already completed
    always_comb begin
        grown = 0;
        if (int'(kcnt) < int'(FIRST_CNT)) begin
            len = CW'(FIRST_LEN);
        end else begin
            grown = FIRST_LEN + GROW * (int'(kcnt) - FIRST_CNT + 1);
            len = (grown > FINAL_LEN) ? CW'(FINAL_LEN) : CW'(grown);
        end
    end

    assign step_done = run && tick && (tcnt == len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
            kcnt <= '0;
        end else if (!run) begin
            tcnt <= '0;
            kcnt <= '0;
        end else if (step_done) begin
            tcnt <= '0;
            if (int'(len) != int'(FINAL_LEN)) kcnt <= kcnt + 1'b1;
        end else if (tick) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    p_tick_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (tcnt < len));
endmodule

// File: rtl/sss_stop_det.sv
module sss_stop_det #(
    parameter int unsigned STOP_TO = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic zc,
    output logic stop_hit
);
    localparam int unsigned SW = $clog2(STOP_TO + 1);

    logic [SW-1:0] cnt;

    assign stop_hit = run && !zc && (int'(cnt) == int'(STOP_TO - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (!run || zc || stop_hit) cnt <= '0;
        else                         cnt <= cnt + 1'b1;
    end

    p_stop_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (int'(cnt) < int'(STOP_TO)));
endmodule

// File: rtl/sss_phase_dec.sv
module sss_phase_dec
    import sss_pkg::*;
(
    input  mode_e      mode,
    input  logic [2:0] step,
    output logic [1:0] ph_u,
    output logic [1:0] ph_v,
    output logic [1:0] ph_w
);
    int src_i;
    int snk_i;
    logic [1:0] ph [3];

    always_comb begin
        src_i = 0;
        snk_i = 1;
        unique case (step)
            3'd0: begin src_i = 0; snk_i = 1; end
            3'd1: begin src_i = 0; snk_i = 2; end
            3'd2: begin src_i = 1; snk_i = 2; end
            3'd3: begin src_i = 1; snk_i = 0; end
            3'd4: begin src_i = 2; snk_i = 0; end
            3'd5: begin src_i = 2; snk_i = 1; end
            default: begin src_i = 0; snk_i = 1; end
        endcase
        for (int i = 0; i < 3; i++) begin
            unique case (mode)
                MODE_BRAKE:          ph[i] = PH_SINK;
                MODE_SYNC, MODE_RUN: ph[i] = (i == src_i) ? PH_SRC :
                                             (i == snk_i) ? PH_SINK : PH_OFF;
                default:             ph[i] = PH_OFF;
            endcase
        end
    end

    assign ph_u = ph[0];
    assign ph_v = ph[1];
    assign ph_w = ph[2];
endmodule

// File: rtl/spin_start_seq.sv
module spin_start_seq
    import sss_pkg::*;
#(
    parameter int unsigned FIRST_LEN = 4,
    parameter int unsigned FIRST_CNT = 5,
    parameter int unsigned GROW      = 2,
    parameter int unsigned FINAL_LEN = 16,
    parameter int unsigned ZC_LOCK   = 2,
    parameter int unsigned STOP_TO   = 2000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       zc_pulse,
    input  logic [1:0] spn_en,
    input  logic       ovt,
    input  logic       pwr_ok,
    input  logic       restart_inh,
    output logic [1:0] ph_u,
    output logic [1:0] ph_v,
    output logic [1:0] ph_w,
    output logic [1:0] mode
);
    localparam int unsigned ZW = $clog2(ZC_LOCK + 1);

    mode_e         st_q, st_d;
    logic [2:0]    step_q;
    logic [ZW-1:0] zc_cnt;
    logic          inh_q;
    logic          step_done;
    logic          stop_hit;
    logic          commutating;

    sss_step_timer #(
        .FIRST_LEN(FIRST_LEN), .FIRST_CNT(FIRST_CNT),
        .GROW(GROW), .FINAL_LEN(FINAL_LEN)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .run(st_q == MODE_SYNC),
        .tick(osc_tick), .step_done(step_done)
    );

    sss_stop_det #(.STOP_TO(STOP_TO)) u_stop (
        .clk(clk), .rst_n(rst_n), .run(st_q == MODE_RUN),
        .zc(zc_pulse), .stop_hit(stop_hit)
    );

    // Next-state logic: faults first, then enable, then sequencing
    always_comb begin
        st_d = st_q;
        if (ovt || !pwr_ok) begin
            st_d = MODE_OFF;
        end else if (spn_en == EN_BRAKE) begin
            st_d = MODE_BRAKE;
        end else if (spn_en != EN_DRIVE) begin
            st_d = MODE_OFF;
        end else begin
            unique case (st_q)
                MODE_OFF, MODE_BRAKE: if (!inh_q) st_d = MODE_SYNC;
                MODE_SYNC: if (zc_pulse && int'(zc_cnt) == int'(ZC_LOCK - 1)) st_d = MODE_RUN;
                MODE_RUN:  if (stop_hit) st_d = MODE_SYNC;
                default:   st_d = MODE_OFF;
            endcase
        end
    end

    // State register and sequencing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= MODE_OFF;
            step_q <= '0;
            zc_cnt <= '0;
            inh_q  <= 1'b0;
        end else begin
            st_q <= st_d;

            if (st_d == MODE_SYNC && st_q != MODE_SYNC)
                step_q <= '0;
            else if ((st_q == MODE_SYNC && step_done) ||
                     (st_q == MODE_RUN && zc_pulse && st_d == MODE_RUN))
                step_q <= (step_q == 3'd5) ? 3'd0 : step_q + 3'd1;

            if (st_q != MODE_SYNC)
                zc_cnt <= '0;
            else if (zc_pulse && int'(zc_cnt) < int'(ZC_LOCK))
                zc_cnt <= zc_cnt + 1'b1;

            if (!pwr_ok && restart_inh && (st_q == MODE_SYNC || st_q == MODE_RUN))
                inh_q <= 1'b1;
            else if (spn_en != EN_DRIVE)
                inh_q <= 1'b0;
        end
    end

    // Outputs
    sss_phase_dec u_dec (
        .mode(st_q), .step(step_q),
        .ph_u(ph_u), .ph_v(ph_v), .ph_w(ph_w)
    );

    always_comb begin
        mode        = st_q;
        commutating = (st_q == MODE_SYNC) || (st_q == MODE_RUN);
    end

    p_one_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commutating |-> ($countones({ph_u == PH_SRC, ph_v == PH_SRC, ph_w == PH_SRC}) == 1 &&
                         $countones({ph_u == PH_SINK, ph_v == PH_SINK, ph_w == PH_SINK}) == 1));

    p_brake_sink_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BRAKE) |-> ({ph_u, ph_v, ph_w} == {PH_SINK, PH_SINK, PH_SINK}));

    p_fault_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovt || !pwr_ok) |=> (mode == MODE_OFF));

    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |-> ({ph_u, ph_v, ph_w} == 6'b0));

    p_inh_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inh_q |-> !commutating);
endmodule

// File: tb/spin_start_seq_tb.sv
module spin_start_seq_tb;
    localparam int unsigned STOP_TO = 300;
    localparam int unsigned ZC_LOCK = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 1'b0;
    logic zc_pulse = 1'b0;
    logic [1:0] spn_en = 2'b00;
    logic ovt = 1'b0;
    logic pwr_ok = 1'b1;
    logic restart_inh = 1'b0;
    logic [1:0] ph_u, ph_v, ph_w, mode;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5ns clk = ~clk;

    spin_start_seq #(.ZC_LOCK(ZC_LOCK), .STOP_TO(STOP_TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .zc_pulse(zc_pulse),
        .spn_en(spn_en), .ovt(ovt), .pwr_ok(pwr_ok), .restart_inh(restart_inh),
        .ph_u(ph_u), .ph_v(ph_v), .ph_w(ph_w), .mode(mode)
    );

    function automatic int step_len(input int k);
        if (k < 5) return 4;
        if (k < 10) return 4 + 2 * (k - 4);
        return 16;
    endfunction

    // Expected {mode, U, V, W}
    function automatic logic [7:0] exp_pat(input logic [1:0] m, input int s);
        logic [1:0] p [3];
        int so, si;
        so = s / 2;
        case (s)
            0: si = 1; 1: si = 2; 2: si = 2;
            3: si = 0; 4: si = 0; default: si = 1;
        endcase
        for (int i = 0; i < 3; i++) p[i] = 2'b00;
        if (m == 2'b01) begin
            for (int i = 0; i < 3; i++) p[i] = 2'b10;
        end else if (m[1]) begin
            p[so] = 2'b01;
            p[si] = 2'b10;
        end
        return {m, p[0], p[1], p[2]};
    endfunction

    task automatic chk(input string req, input logic [7:0] exp);
        logic [7:0] act;
        act = {mode, ph_u, ph_v, ph_w};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_tick();
        osc_tick = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0;
    endtask

    task automatic do_zc();
        zc_pulse = 1'b1;
        @(negedge clk);
        zc_pulse = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int idx, k, cnt;
        void'($urandom(32'h1357));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R10 reset off", exp_pat(2'b00, 0));

        do_zc();
        chk("R3 zc ignored in off", exp_pat(2'b00, 0));

        spn_en = 2'b10;
        cyc(1);
        chk("R5 drive enters sync step0", exp_pat(2'b10, 0));

        // Open-loop schedule with random tick spacing
        idx = 0; k = 0; cnt = 0;
        for (int n = 0; n < 100; n++) begin
            cyc($urandom_range(0, 3));
            do_tick();
            cnt++;
            if (cnt == step_len(k)) begin
                cnt = 0;
                k++;
                idx = (idx + 1) % 6;
            end
            chk("R1 R2 schedule step", exp_pat(2'b10, idx));
        end

        // Lock after ZC_LOCK crossings
        do_zc();
        chk("R3 first crossing stays sync", exp_pat(2'b10, idx));
        cyc(2);
        do_zc();
        chk("R3 lock to run no step", exp_pat(2'b11, idx));

        do_tick();
        chk("R3 tick ignored in run", exp_pat(2'b11, idx));

        for (int n = 0; n < 8; n++) begin
            cyc($urandom_range(0, 20));
            do_zc();
            idx = (idx + 1) % 6;
            chk("R3 run crossing advances", exp_pat(2'b11, idx));
        end

        // Stop timeout
        cyc(STOP_TO - 1);
        chk("R4 still run before timeout", exp_pat(2'b11, idx));
        cyc(1);
        chk("R4 restart sync step0", exp_pat(2'b10, 0));

        // Brake then open
        spn_en = 2'b01;
        cyc(1);
        chk("R6 brake all sink", exp_pat(2'b01, 0));
        cyc(30);
        chk("R6 brake held", exp_pat(2'b01, 0));
        spn_en = 2'b00;
        cyc(1);
        chk("R5 open gives off", exp_pat(2'b00, 0));

        // Over-temperature
        spn_en = 2'b10;
        cyc(1);
        chk("R5 drive again", exp_pat(2'b10, 0));
        ovt = 1'b1;
        cyc(1);
        chk("R7 ovt forces off", exp_pat(2'b00, 0));
        cyc(10);
        chk("R7 ovt held off", exp_pat(2'b00, 0));
        ovt = 1'b0;
        cyc(1);
        chk("R7 ovt clear resumes sync", exp_pat(2'b10, 0));

        // Power loss with restart inhibit
        restart_inh = 1'b1;
        pwr_ok = 1'b0;
        cyc(1);
        chk("R7 power loss off", exp_pat(2'b00, 0));
        pwr_ok = 1'b1;
        cyc(6);
        chk("R8 inhibited stays off", exp_pat(2'b00, 0));
        spn_en = 2'b00;
        cyc(1);
        spn_en = 2'b10;
        cyc(1);
        chk("R8 fresh enable restarts", exp_pat(2'b10, 0));

        // Power loss without inhibit
        restart_inh = 1'b0;
        pwr_ok = 1'b0;
        cyc(1);
        chk("R7 power loss off again", exp_pat(2'b00, 0));
        pwr_ok = 1'b1;
        cyc(1);
        chk("R8 auto restart", exp_pat(2'b10, 0));

        spn_en = 2'b11;
        cyc(1);
        chk("R5 code 11 is open", exp_pat(2'b00, 0));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule